// File: doc/BRIEF.md
# Two-Level Page Table Refill Walker

This block refills a software-managed TLB in hardware after a lookup has missed. A single start pulse hands it the faulting virtual address, the access type and the page-directory base pointer. The walker then reads a directory word, follows it to a page table, reads an even/odd pair of page-table entries, and converts each entry into hardware EntryLo form. It writes the pair, with a matching EntryHi, into the TLB slot named by the pseudo-random index. Finally it reports the outcome of the original access together with the translated physical address.

All pointers stored in memory are kernel-segment virtual addresses. The walker turns them into physical addresses by subtracting 0x80000000. While the walk runs, the block shows a borrowed view of four control registers: bad address, context, EntryHi and mode. It restores the values that were sampled at start before it reports the result. The TLB array and the memory sit outside the block. Memory is reached through a word-read port that holds its request until the data is valid.

Top module: `ptw_refill`

## Requirements
- R1: A start pulse while idle begins a walk. `busy_o` is high from the next cycle through the cycle of `done_o`, and low in the cycle after. A start pulse while busy is ignored, and input changes after the start cycle do not affect the walk.
- R2: If the directory base is zero, `done_o` rises in the cycle after start with result code 3 (no match). No memory read and no TLB write take place.
- R3: The first read goes to (base − 0x80000000) + VA[31:22]·4. A request holds its address steady until `rd_valid_i` is seen.
- R4: With P the directory word just read, the next two reads go to (P − 0x80000000) + VA[21:13]·8, first to the even entry at offset 0 and then to the odd entry at offset 4.
- R5: Each EntryLo value is its page-table word shifted right logically by 6.
- R6: After the odd read there is a one-cycle TLB write with index equal to `rand_idx_i` in that cycle, EntryHi = ASID | (VA with bits 12:0 cleared), and even/odd EntryLo. `done_o` follows in the next cycle.
- R7: In the cycle after a start with a non-zero base, the views show bad address = VA, context = (context & ~0x7FFFFF) | ((VA >> 9) & 0x7FFFF0), EntryHi as in R6, and mode = the kernel-mode parameter.
- R8: From the `done_o` cycle on, the four views equal the input values sampled at start, whatever the result.
- R9: The selected EntryLo is the odd one when VA[12] is 1. If its bit 1 (valid) is 0 the result is 1 (invalid). Otherwise the result is 0 (match) for a read or when bit 2 (dirty) is set, and 2 (dirty fault) for a write to a clean page.
- R10: For a walk that reaches memory, `pa_o` in the `done_o` cycle is ((EntryLo >> 6) << 12) | VA[11:0] of the selected entry.
- R11: After reset the block is idle, with no request, no TLB write, no done and all views zero, and at most one of request, write and done is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only while idle) |
| fault_va_i | input | 32 | Faulting virtual address |
| is_write_i | input | 1 | Faulting access is a store |
| pgd_base_i | input | 32 | Page-directory base pointer (kernel virtual) |
| rand_idx_i | input | IDX_W | Pseudo-random TLB slot |
| badva_i | input | 32 | Current bad-address register |
| context_i | input | 32 | Current context register |
| entryhi_i | input | 32 | Current EntryHi (ASID in low bits) |
| mode_i | input | MODE_W | Current mode flags |
| rd_req_o | output | 1 | Memory word read request |
| rd_addr_o | output | 32 | Physical byte address of the read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| tlb_we_o | output | 1 | TLB write strobe |
| tlb_idx_o | output | IDX_W | TLB slot being written |
| tlb_hi_o | output | 32 | EntryHi to write |
| tlb_lo0_o | output | 32 | Even EntryLo |
| tlb_lo1_o | output | 32 | Odd EntryLo |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid this cycle |
| result_o | output | 2 | 0 match, 1 invalid, 2 dirty fault, 3 no match |
| pa_o | output | 32 | Translated physical address |
| badva_o | output | 32 | Bad-address view |
| context_o | output | 32 | Context view |
| entryhi_o | output | 32 | EntryHi view |
| mode_o | output | MODE_W | Mode view |

## Verification
The walk view is due one cycle after the start edge, and the restored view, result and address arrive with `done_o`. The bench samples each of these on the falling edge. The no-match result comes exactly one cycle after start. For a walk that reaches memory, the TLB write comes one cycle after the edge that accepts the odd word, and `done_o` one cycle after that. Memory latency is randomised per walk between zero and two extra cycles, so the bench does not count a fixed number of cycles. It steps falling edge by falling edge and captures the write and the result in whichever cycle their strobes are seen. It then confirms that `busy_o` drops on the next edge.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam logic [31:0] KSEG_OFFSET = 32'h8000_0000;
   localparam logic [31:0] CTX_KEEP    = 32'hFF80_0000;
   localparam logic [31:0] CTX_VPN     = 32'h007F_FFF0;
   localparam int          LO_SHIFT    = 6;
   localparam int          PAGE_SHIFT  = 12;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DIR, ST_EVEN, ST_ODD, ST_WR, ST_DONE
   } ptw_state_e;

   typedef enum logic [1:0] {
      RES_MATCH   = 2'd0,
      RES_INVALID = 2'd1,
      RES_DIRTY   = 2'd2,
      RES_NOMATCH = 2'd3
   } ptw_res_e;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr
   import ptw_pkg::*;
(
   input  logic [31:0] va,
   input  logic [31:0] dir_base,
   input  logic [31:0] tbl_ptr,
   output logic [31:0] dir_addr,
   output logic [31:0] pte_even_addr
);
   always_comb begin
      dir_addr      = (dir_base - KSEG_OFFSET) + {20'd0, va[31:22], 2'b00};
      pte_even_addr = (tbl_ptr - KSEG_OFFSET) + {20'd0, va[21:13], 3'b000};
   end
endmodule

// File: rtl/ptw_cp0_view.sv
module ptw_cp0_view
   import ptw_pkg::*;
#(
   parameter int ASID_W = 8
) (
   input  logic [31:0] va,
   input  logic [31:0] ctx_cur,
   input  logic [31:0] ehi_cur,
   output logic [31:0] ctx_walk,
   output logic [31:0] ehi_walk
);
   always_comb begin
      ctx_walk = (ctx_cur & CTX_KEEP) | ((va >> 9) & CTX_VPN);
      ehi_walk = {va[31:13], 13'd0} | {{(32-ASID_W){1'b0}}, ehi_cur[ASID_W-1:0]};
   end
endmodule

// File: rtl/ptw_eval.sv
module ptw_eval
   import ptw_pkg::*;
(
   input  logic [31:0] lo_even,
   input  logic [31:0] lo_odd,
   input  logic [12:0] va_low,
   input  logic        is_write,
   output logic [1:0]  res,
   output logic [31:0] pa
);
   logic [31:0] sel;
   always_comb begin
      sel = va_low[12] ? lo_odd : lo_even;
      pa  = ((sel >> LO_SHIFT) << PAGE_SHIFT) | {20'd0, va_low[11:0]};
      if (!sel[1])
         res = RES_INVALID;
      else if (!is_write || sel[2])
         res = RES_MATCH;
      else
         res = RES_DIRTY;
   end
endmodule

// File: rtl/ptw_refill.sv
module ptw_refill
   import ptw_pkg::*;
#(
   parameter int              TLB_ENTRIES = 64,
   parameter int              ASID_W      = 8,
   parameter int              MODE_W      = 3,
   parameter logic [MODE_W-1:0] KMODE     = '0,
   localparam int             IDX_W       = $clog2(TLB_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [31:0]       fault_va_i,
   input  logic              is_write_i,
   input  logic [31:0]       pgd_base_i,
   input  logic [IDX_W-1:0]  rand_idx_i,
   input  logic [31:0]       badva_i,
   input  logic [31:0]       context_i,
   input  logic [31:0]       entryhi_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              rd_req_o,
   output logic [31:0]       rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [31:0]       rd_data_i,
   output logic              tlb_we_o,
   output logic [IDX_W-1:0]  tlb_idx_o,
   output logic [31:0]       tlb_hi_o,
   output logic [31:0]       tlb_lo0_o,
   output logic [31:0]       tlb_lo1_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        result_o,
   output logic [31:0]       pa_o,
   output logic [31:0]       badva_o,
   output logic [31:0]       context_o,
   output logic [31:0]       entryhi_o,
   output logic [MODE_W-1:0] mode_o
);
   generate
      if (TLB_ENTRIES < 2) begin : g_bad_entries
         $error("TLB_ENTRIES must be at least 2");
      end
      if (ASID_W < 1 || ASID_W > 13) begin : g_bad_asid
         $error("ASID_W must lie in 1..13");
      end
      if (MODE_W < 1) begin : g_bad_mode
         $error("MODE_W must be positive");
      end
   endgenerate

   ptw_state_e  state_q;
   logic [31:0] va_q, pgd_q, ptr_q, lo0_q, lo1_q;
   logic        wr_q, nomatch_q;
   logic [31:0] sv_bad_q, sv_ctx_q, sv_ehi_q;
   logic [MODE_W-1:0] sv_mode_q;
   logic [31:0] dir_addr, pte_addr, ctx_walk, ehi_walk, eval_pa;
   logic [1:0]  eval_res;
   logic        accept;

   ptw_addr i_addr (
      .va            (va_q),
      .dir_base      (pgd_q),
      .tbl_ptr       (ptr_q),
      .dir_addr      (dir_addr),
      .pte_even_addr (pte_addr)
   );

   ptw_cp0_view #(.ASID_W(ASID_W)) i_view (
      .va       (fault_va_i),
      .ctx_cur  (context_i),
      .ehi_cur  (entryhi_i),
      .ctx_walk (ctx_walk),
      .ehi_walk (ehi_walk)
   );

   ptw_eval i_eval (
      .lo_even  (lo0_q),
      .lo_odd   (lo1_q),
      .va_low   (va_q[12:0]),
      .is_write (wr_q),
      .res      (eval_res),
      .pa       (eval_pa)
   );

   assign accept = rd_req_o && rd_valid_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         va_q      <= '0;
         pgd_q     <= '0;
         ptr_q     <= '0;
         lo0_q     <= '0;
         lo1_q     <= '0;
         wr_q      <= 1'b0;
         nomatch_q <= 1'b0;
         sv_bad_q  <= '0;
         sv_ctx_q  <= '0;
         sv_ehi_q  <= '0;
         sv_mode_q <= '0;
         badva_o   <= '0;
         context_o <= '0;
         entryhi_o <= '0;
         mode_o    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               va_q      <= fault_va_i;
               pgd_q     <= pgd_base_i;
               wr_q      <= is_write_i;
               sv_bad_q  <= badva_i;
               sv_ctx_q  <= context_i;
               sv_ehi_q  <= entryhi_i;
               sv_mode_q <= mode_i;
               if (pgd_base_i == '0) begin
                  nomatch_q <= 1'b1;
                  state_q   <= ST_DONE;
                  badva_o   <= badva_i;
                  context_o <= context_i;
                  entryhi_o <= entryhi_i;
                  mode_o    <= mode_i;
               end else begin
                  nomatch_q <= 1'b0;
                  state_q   <= ST_DIR;
                  badva_o   <= fault_va_i;
                  context_o <= ctx_walk;
                  entryhi_o <= ehi_walk;
                  mode_o    <= KMODE;
               end
            end
            ST_DIR: if (accept) begin
               ptr_q   <= rd_data_i;
               state_q <= ST_EVEN;
            end
            ST_EVEN: if (accept) begin
               lo0_q   <= rd_data_i >> LO_SHIFT;
               state_q <= ST_ODD;
            end
            ST_ODD: if (accept) begin
               lo1_q   <= rd_data_i >> LO_SHIFT;
               state_q <= ST_WR;
            end
            ST_WR: begin
               state_q   <= ST_DONE;
               badva_o   <= sv_bad_q;
               context_o <= sv_ctx_q;
               entryhi_o <= sv_ehi_q;
               mode_o    <= sv_mode_q;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_req_o  = (state_q == ST_DIR) || (state_q == ST_EVEN) || (state_q == ST_ODD);
      unique case (state_q)
         ST_DIR:  rd_addr_o = dir_addr;
         ST_EVEN: rd_addr_o = pte_addr;
         ST_ODD:  rd_addr_o = pte_addr + 32'd4;
         default: rd_addr_o = '0;
      endcase
      tlb_we_o  = (state_q == ST_WR);
      tlb_idx_o = rand_idx_i;
      tlb_hi_o  = entryhi_o;
      tlb_lo0_o = lo0_q;
      tlb_lo1_o = lo1_q;
      busy_o    = (state_q != ST_IDLE);
      done_o    = (state_q == ST_DONE);
      result_o  = nomatch_q ? RES_NOMATCH : eval_res;
      pa_o      = nomatch_q ? '0 : eval_pa;
   end
endmodule

// File: rtl/ptw_refill_chk.sv
module ptw_refill_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        rd_req_o,
   input logic [31:0] rd_addr_o,
   input logic        rd_valid_i,
   input logic        tlb_we_o,
   input logic        busy_o,
   input logic        done_o,
   input logic [1:0]  result_o
);
   a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);
   a_r1_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   a_r1_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));
   a_r6_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_we_o |=> done_o);
   a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req_o, tlb_we_o, done_o}));
   a_r2_nomatch_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o == 2'd3) |-> !$past(busy_o));
endmodule

bind ptw_refill ptw_refill_chk i_ptw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .rd_req_o   (rd_req_o),
   .rd_addr_o  (rd_addr_o),
   .rd_valid_i (rd_valid_i),
   .tlb_we_o   (tlb_we_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .result_o   (result_o)
);

// File: tb/test_ptw_refill.sv
module test_ptw_refill;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, wr = 1'b0, rd_valid = 1'b0;
   logic [31:0] va = '0, pgd = '0, bad_in = '0, ctx_in = '0, ehi_in = '0, rd_data = '0;
   logic [2:0]  mode_in = '0;
   logic [IDX_W-1:0] rnd = '0;
   logic rd_req, tlb_we, busy, done;
   logic [31:0] rd_addr, t_hi, t_lo0, t_lo1, pa, bad_o, ctx_o, ehi_o;
   logic [IDX_W-1:0] t_idx;
   logic [1:0] res;
   logic [2:0] mode_o;

   int tests = 0, fails = 0, cyc = 0;
   int lat = 0, wt = 0, rd_cnt = 0;
   logic [31:0] rd_log [4];
   logic [31:0] salt = 32'h1234_5678;

   ptw_refill #(.TLB_ENTRIES(64), .ASID_W(8), .MODE_W(3), .KMODE(3'b000)) i_ptw_refill (
      .clk(clk), .rst_n(rst_n), .start_i(start), .fault_va_i(va), .is_write_i(wr),
      .pgd_base_i(pgd), .rand_idx_i(rnd), .badva_i(bad_in), .context_i(ctx_in),
      .entryhi_i(ehi_in), .mode_i(mode_in), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
      .rd_valid_i(rd_valid), .rd_data_i(rd_data), .tlb_we_o(tlb_we), .tlb_idx_o(t_idx),
      .tlb_hi_o(t_hi), .tlb_lo0_o(t_lo0), .tlb_lo1_o(t_lo1), .busy_o(busy), .done_o(done),
      .result_o(res), .pa_o(pa), .badva_o(bad_o), .context_o(ctx_o), .entryhi_o(ehi_o),
      .mode_o(mode_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] h;
      h = (a ^ salt) * 32'h9E37_79B1;
      return h ^ ((h >> 15) * 32'h85EB_CA6B);
   endfunction

   // behavioural memory with per-walk latency
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_valid = 1'b0; wt = 0;
      end else if (rd_valid) begin
         rd_valid = 1'b0; wt = 0;
      end else if (rd_req) begin
         if (wt >= lat) begin
            rd_valid = 1'b1;
            rd_data  = mem_word(rd_addr);
            if (rd_cnt < 4) rd_log[rd_cnt] = rd_addr;
            rd_cnt++;
         end else wt++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic run_walk(input logic [31:0] a_va, input logic a_wr, input logic [31:0] a_pgd,
                           input logic [IDX_W-1:0] a_rnd, input int a_lat);
      logic [31:0] e_bad, e_ctx, e_ehi, p, pte, lo0, lo1, sel, e_hi;
      logic [2:0]  e_mode;
      logic [1:0]  e_res;
      logic [31:0] c_hi, c_lo0, c_lo1, c_res, c_pa, c_bad, c_ctx, c_ehi, c_mode;
      logic [IDX_W-1:0] c_idx;
      int we_seen, got;
      @(negedge clk);
      va = a_va; wr = a_wr; pgd = a_pgd; rnd = a_rnd; lat = a_lat; rd_cnt = 0;
      bad_in = $urandom; ctx_in = $urandom; ehi_in = $urandom; mode_in = 3'($urandom);
      e_bad = bad_in; e_ctx = ctx_in; e_ehi = ehi_in; e_mode = mode_in;
      start = 1'b1;
      e_hi = {a_va[31:13], 13'd0} | {24'd0, e_ehi[7:0]};
      @(negedge clk);
      we_seen = 0; got = 0;
      c_hi = 0; c_lo0 = 0; c_lo1 = 0; c_idx = 0; c_res = 0; c_pa = 0;
      c_bad = 0; c_ctx = 0; c_ehi = 0; c_mode = 0;
      for (int i = 0; i < 80; i++) begin
         if (i == 0) begin
            chk("R1 busy after start", 32'(busy), 32'd1);
            if (a_pgd != 0) begin
               chk("R7 walk badva", bad_o, a_va);
               chk("R7 walk context", ctx_o, (e_ctx & 32'hFF80_0000) | ((a_va >> 9) & 32'h007F_FFF0));
               chk("R7 walk entryhi", ehi_o, e_hi);
               chk("R7 walk mode", 32'(mode_o), 32'd0);
            end
            // R1: a second start with altered inputs while busy is ignored
            va = ~a_va; wr = ~a_wr; pgd = ~a_pgd; bad_in = ~e_bad; ctx_in = ~e_ctx;
            ehi_in = ~e_ehi; mode_in = ~e_mode;
         end else start = 1'b0;
         if (tlb_we) begin
            we_seen++; c_idx = t_idx; c_hi = t_hi; c_lo0 = t_lo0; c_lo1 = t_lo1;
         end
         if (done) begin
            got = 1; c_res = 32'(res); c_pa = pa;
            c_bad = bad_o; c_ctx = ctx_o; c_ehi = ehi_o; c_mode = 32'(mode_o);
            break;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R1 walk completes", 32'(got), 32'd1);
      @(negedge clk);
      chk("R1 idle after done", 32'(busy), 32'd0);
      chk("R8 restored badva", c_bad, e_bad);
      chk("R8 restored context", c_ctx, e_ctx);
      chk("R8 restored entryhi", c_ehi, e_ehi);
      chk("R8 restored mode", c_mode, 32'(e_mode));
      if (a_pgd == 0) begin
         chk("R2 nomatch code", c_res, 32'd3);
         chk("R2 no reads", 32'(rd_cnt), 32'd0);
         chk("R2 no tlb write", 32'(we_seen), 32'd0);
      end else begin
         chk("R3 dir addr", rd_log[0], (a_pgd - 32'h8000_0000) + {20'd0, a_va[31:22], 2'b00});
         p   = mem_word(rd_log[0]);
         pte = (p - 32'h8000_0000) + {20'd0, a_va[21:13], 3'b000};
         chk("R4 read count", 32'(rd_cnt), 32'd3);
         chk("R4 even addr", rd_log[1], pte);
         chk("R4 odd addr", rd_log[2], pte + 32'd4);
         lo0 = mem_word(pte) >> 6;
         lo1 = mem_word(pte + 32'd4) >> 6;
         chk("R6 one write", 32'(we_seen), 32'd1);
         chk("R6 index", 32'(c_idx), 32'(a_rnd));
         chk("R6 entryhi", c_hi, e_hi);
         chk("R5 lo even", c_lo0, lo0);
         chk("R5 lo odd", c_lo1, lo1);
         sel = a_va[12] ? lo1 : lo0;
         if (!sel[1]) e_res = 2'd1;
         else if (!a_wr || sel[2]) e_res = 2'd0;
         else e_res = 2'd2;
         chk("R9 result", c_res, 32'(e_res));
         chk("R10 pa", c_pa, ((sel >> 6) << 12) | {20'd0, a_va[11:0]});
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset busy", 32'(busy), 32'd0);
      chk("R11 reset req", 32'(rd_req), 32'd0);
      chk("R11 reset write", 32'(tlb_we), 32'd0);
      chk("R11 reset done", 32'(done), 32'd0);
      chk("R11 reset views", bad_o | ctx_o | ehi_o | 32'(mode_o), 32'd0);
      // directed corners
      run_walk(32'h0040_1000, 1'b0, 32'd0, 6'd5, 0);
      run_walk(32'h0000_0000, 1'b0, 32'h8033_B000, 6'd0, 0);
      run_walk(32'hFFFF_FFFF, 1'b1, 32'h8033_B000, 6'd63, 2);
      run_walk(32'h7FFF_E000, 1'b1, 32'h8000_0000, 6'd17, 1);
      run_walk(32'h1234_5678, 1'b0, 32'd0, 6'd9, 2);
      // random walks
      for (int n = 0; n < 60; n++) begin
         salt = $urandom;
         run_walk($urandom, 1'($urandom), ($urandom % 8 == 0) ? 32'd0 : $urandom,
                  6'($urandom), int'($urandom % 3));
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule